// File: doc/BRIEF.md
# System Configuration Controller

This block is a 32-bit register file on a simple memory-mapped bus with a 4 KB address window. It holds two general-purpose configuration words, one of which drives an 8-bit LED output. It also holds fixed identity words, a clock-lock status word, and a configuration channel that reaches a small bank of oscillator-frequency registers.

Software uses the channel as follows. It places the data in the outgoing-data register and then writes a command word that carries a device number, a function code, a direction flag and a go flag. The transaction finishes in the same clock edge as the command write. The result is a done flag, plus an error flag when the target is not addressable. A successful read leaves the oscillator value in the returned-data register. There is no busy state, so status can be read on the very next access.

Bus writes take effect at the rising clock edge when `bus_valid` and `bus_write` are both high. Reads are combinational: while `bus_valid` is high and `bus_write` is low, `bus_rdata` shows the addressed register. Addresses are byte addresses. Only bits [11:2] select a word.

Top module: `sys_cfg_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the registers read as follows. Command word reads 0x00100000. Lock word reads 0xFFFF0001 when all loop-lock inputs are high. Both general words, outgoing data, returned data and status read 0. `led_out` is 0.
- R2: The word map is: general word A at 0x000, general word B at 0x004, a zero word at 0x00C, a fixed config word at 0x010, returned data at 0x0A0, outgoing data at 0x0A4, command at 0x0A8, status at 0x0AC, lock at 0x100, auxiliary identity at 0xFF8 and identity at 0xFFC. The word at 0x00C and every unmapped offset read as zero. The three fixed words read their parameter values.
- R3: Writes to unmapped offsets, to the fixed words, to the zero word, to returned data and to status change no register.
- R4: A command write stores only bits [11:0] (device), [25:20] (function) and bit 30 (write direction). Bits [19:12], [29:26] and bit 31 (go) read back as zero.
- R5: Any command write clears status. If bit 31 of the written value is set, status bit 0 (done) is set by the same edge.
- R6: A started transaction is valid only when function equals 1 and device is below the oscillator count (3). Otherwise status bit 1 (error) is set along with done.
- R7: A valid started transaction with bit 30 set copies outgoing data into the oscillator selected by device. No other event changes an oscillator.
- R8: A valid started transaction with bit 30 clear loads the selected oscillator into returned data. A failed read leaves returned data unchanged.
- R9: Oscillators reset to parameter values, by default 50000000, 24576000 and 25000000 for devices 0, 1 and 2.
- R10: Only lock-word bits [31:24] (a mask, reset 0xFF) are writable. Bits [23:16] mirror `loop_locked`. Bit 0 is the OR of `loop_locked` bits selected by the mask. All other bits read zero.
- R11: General words A and B are fully writable 32-bit registers. `led_out` equals bits [7:0] of word B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| loop_locked | input | 8 | Per-loop lock flags |
| led_out | output | 8 | LED drive from general word B |

## Verification
The following properties hold on every cycle, so assertions check them continuously:
- At most one register is decoded at a time.
- Error never appears without done.
- Reserved command bits stay zero.
- A command write without go leaves status clear, and one with go sets done.
- An oscillator changes only under a valid write transaction.
- A failed read leaves returned data alone.
- The LEDs move only on a write to word B.
- The lock mask moves only on its own write, and the combined lock bit is low with an empty mask.

Other behaviour depends on specific stimulus and only the bench scenarios can show it. This covers the exact values that land in oscillators and returned data, the error decision across function/device mixes, and the effect of writes to read-only and unmapped offsets.

// File: rtl/sys_cfg_pkg.sv
// Shared constants for the system configuration controller.
// Assumes 32-bit data words and a 12-bit byte address window.
package sys_cfg_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    // Byte offsets of the mapped words
    localparam logic [ADDR_W-1:0] OFF_GEN_A   = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_GEN_B   = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_ZERO    = 12'h00C;
    localparam logic [ADDR_W-1:0] OFF_FIXCFG  = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_RTN     = 12'h0A0;
    localparam logic [ADDR_W-1:0] OFF_DOUT    = 12'h0A4;
    localparam logic [ADDR_W-1:0] OFF_CMD     = 12'h0A8;
    localparam logic [ADDR_W-1:0] OFF_STAT    = 12'h0AC;
    localparam logic [ADDR_W-1:0] OFF_LOCK    = 12'h100;
    localparam logic [ADDR_W-1:0] OFF_AUXID   = 12'hFF8;
    localparam logic [ADDR_W-1:0] OFF_ID      = 12'hFFC;

    // Command word field layout
    localparam int DEV_LSB  = 0;
    localparam int DEV_W    = 12;
    localparam int FUNC_LSB = 20;
    localparam int FUNC_W   = 6;
    localparam int DIR_BIT  = 30;
    localparam int GO_BIT   = 31;
    localparam logic [DATA_W-1:0] CMD_KEEP  = 32'h43F0_0FFF;
    localparam logic [DATA_W-1:0] CMD_RESET = 32'h0010_0000;
    localparam logic [FUNC_W-1:0] FUNC_OSC  = 6'd1;

    // Lock word layout
    localparam int LOOP_N    = 8;
    localparam int MASK_LSB  = 24;
    localparam int FLAG_LSB  = 16;

    // One select line per mapped word
    typedef struct packed {
        logic gen_a;
        logic gen_b;
        logic zero;
        logic fixcfg;
        logic rtn;
        logic dout;
        logic cmd;
        logic stat;
        logic lock;
        logic auxid;
        logic id;
    } sel_t;
endpackage

// File: rtl/cfg_addr_decode.sv
// Address decoder: turns a byte address into one select line per mapped
// word. Assumes word-aligned access; address bits [1:0] are ignored.
module cfg_addr_decode
    import sys_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output sel_t              sel
);
    localparam int WA_MSB = ADDR_W - 1;

    logic [WA_MSB-2:0] word;
    assign word = addr[WA_MSB:2];

    // Compare the word index against each mapped offset
    always_comb begin
        sel        = '0;
        sel.gen_a  = (word == OFF_GEN_A[WA_MSB:2]);
        sel.gen_b  = (word == OFF_GEN_B[WA_MSB:2]);
        sel.zero   = (word == OFF_ZERO[WA_MSB:2]);
        sel.fixcfg = (word == OFF_FIXCFG[WA_MSB:2]);
        sel.rtn    = (word == OFF_RTN[WA_MSB:2]);
        sel.dout   = (word == OFF_DOUT[WA_MSB:2]);
        sel.cmd    = (word == OFF_CMD[WA_MSB:2]);
        sel.stat   = (word == OFF_STAT[WA_MSB:2]);
        sel.lock   = (word == OFF_LOCK[WA_MSB:2]);
        sel.auxid  = (word == OFF_AUXID[WA_MSB:2]);
        sel.id     = (word == OFF_ID[WA_MSB:2]);
    end

    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
endmodule

// File: rtl/cfg_gp_regs.sv
// General-purpose configuration words A and B. Word B's low byte drives
// the LED output. Assumes write strobes are already qualified by decode.
module cfg_gp_regs
    import sys_cfg_pkg::*;
#(
    parameter int LED_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] gen_a_q,
    output logic [DATA_W-1:0] gen_b_q,
    output logic [LED_W-1:0]  led_out
);
    // Hold word A
    always_ff @(posedge clk) begin
        if (!rst_n)    gen_a_q <= '0;
        else if (wr_a) gen_a_q <= wdata;
    end

    // Hold word B
    always_ff @(posedge clk) begin
        if (!rst_n)    gen_b_q <= '0;
        else if (wr_b) gen_b_q <= wdata;
    end

    assign led_out = gen_b_q[LED_W-1:0];

    // R11
    led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_b |=> $stable(led_out));
endmodule

// File: rtl/cfg_lock_reg.sv
// Clock-lock status word. Only the mask byte is stored. The flag byte
// mirrors the inputs, and bit 0 is the OR of the flags the mask selects.
// Assumes loop_locked is synchronous to clk.
module cfg_lock_reg
    import sys_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LOOP_N-1:0] loop_locked,
    output logic [DATA_W-1:0] lock_word
);
    localparam int PAD_W = FLAG_LSB - 1;

    logic [LOOP_N-1:0] mask_q;
    logic              any_locked;

    // Capture the writable mask byte
    always_ff @(posedge clk) begin
        if (!rst_n)  mask_q <= '1;
        else if (wr) mask_q <= wdata[MASK_LSB +: LOOP_N];
    end

    // Combine the selected lock flags
    always_comb begin
        any_locked = 1'b0;
        for (int k = 0; k < LOOP_N; k++)
            any_locked = any_locked | (mask_q[k] & loop_locked[k]);
    end

    assign lock_word = {mask_q, loop_locked, {PAD_W{1'b0}}, any_locked};

    // R10
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(mask_q));
    // R10
    empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !lock_word[0]);
endmodule

// File: rtl/cfg_xact_unit.sv
// Configuration channel: command, status, outgoing and returned data, and
// the oscillator bank. A command write with go set runs one transaction in
// the same edge. Assumes at most one write strobe is active per cycle.
module cfg_xact_unit
    import sys_cfg_pkg::*;
#(
    parameter int                       NUM_OSC   = 3,
    parameter logic [NUM_OSC*DATA_W-1:0] OSC_RESET = {32'd25000000, 32'd24576000, 32'd50000000}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic              wr_dout,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cmd_q,
    output logic [DATA_W-1:0] stat_q,
    output logic [DATA_W-1:0] dout_q,
    output logic [DATA_W-1:0] rtn_q
);
    localparam logic [DEV_W-1:0] DEV_LIMIT = DEV_W'(NUM_OSC);

    logic [DEV_W-1:0]  dev;
    logic [FUNC_W-1:0] func;
    logic              go, dir_wr, target_ok;
    logic              run_wr, run_rd;
    logic [DATA_W-1:0] osc_q [NUM_OSC];
    logic [DATA_W-1:0] osc_sel;

    // Decode the fields of the value being written
    always_comb begin
        dev       = wdata[DEV_LSB +: DEV_W];
        func      = wdata[FUNC_LSB +: FUNC_W];
        go        = wdata[GO_BIT];
        dir_wr    = wdata[DIR_BIT];
        target_ok = (func == FUNC_OSC) && (dev < DEV_LIMIT);
        run_wr    = wr_cmd && go && dir_wr && target_ok;
        run_rd    = wr_cmd && go && !dir_wr && target_ok;
    end

    // Store the command with reserved and go bits dropped
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= CMD_RESET;
        else if (wr_cmd) cmd_q <= wdata & CMD_KEEP;
    end

    // Clear status on a command write and report the result if started
    always_ff @(posedge clk) begin
        if (!rst_n)      stat_q <= '0;
        else if (wr_cmd) stat_q <= {{(DATA_W-2){1'b0}}, go && !target_ok, go};
    end

    // Hold outgoing data
    always_ff @(posedge clk) begin
        if (!rst_n)       dout_q <= '0;
        else if (wr_dout) dout_q <= wdata;
    end

    // Pick the oscillator addressed by the device field
    always_comb begin
        osc_sel = '0;
        for (int k = 0; k < NUM_OSC; k++)
            if (dev == DEV_W'(k)) osc_sel = osc_q[k];
    end

    // Load returned data on a valid read transaction
    always_ff @(posedge clk) begin
        if (!rst_n)      rtn_q <= '0;
        else if (run_rd) rtn_q <= osc_sel;
    end

    for (genvar i = 0; i < NUM_OSC; i++) begin : g_osc
        // Update one oscillator on a valid write transaction
        always_ff @(posedge clk) begin
            if (!rst_n)                            osc_q[i] <= OSC_RESET[i*DATA_W +: DATA_W];
            else if (run_wr && dev == DEV_W'(i))   osc_q[i] <= dout_q;
        end

        // R7
        osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_cmd && go && dir_wr && func == FUNC_OSC && dev == DEV_W'(i))
            |=> $stable(osc_q[i]));
    end

    // R4
    cmd_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q & ~CMD_KEEP) == '0);
    // R5
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !wdata[GO_BIT]) |=> (stat_q == '0));
    // R5
    stat_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && wdata[GO_BIT]) |=> stat_q[0]);
    // R6
    err_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[1] |-> stat_q[0]);
    // R8
    bad_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && go && !dir_wr && (func != FUNC_OSC || dev >= DEV_LIMIT))
        |=> $stable(rtn_q));
endmodule

// File: rtl/sys_cfg_ctrl.sv
// System configuration controller top: address decode, write strobes and
// the read multiplexer around the register sub-blocks. Assumes one access
// per cycle; read data is combinational and zero when not reading.
module sys_cfg_ctrl
    import sys_cfg_pkg::*;
#(
    parameter int                        NUM_OSC    = 3,
    parameter logic [NUM_OSC*DATA_W-1:0] OSC_RESET  = {32'd25000000, 32'd24576000, 32'd50000000},
    parameter logic [DATA_W-1:0]         FIXCFG_VAL = 32'h0000_0000,
    parameter logic [DATA_W-1:0]         AUXID_VAL  = 32'h0100_0001,
    parameter logic [DATA_W-1:0]         ID_VAL     = 32'h4104_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [7:0]        loop_locked,
    output logic [7:0]        led_out
);
    localparam int LED_W = 8;

    sel_t              sel;
    logic              wr_en;
    logic [DATA_W-1:0] gen_a_q, gen_b_q, cmd_q, stat_q, dout_q, rtn_q, lock_word;

    assign wr_en = bus_valid && bus_write;

    cfg_addr_decode u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .sel   (sel)
    );

    cfg_gp_regs #(.LED_W(LED_W)) u_gp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_a    (wr_en && sel.gen_a),
        .wr_b    (wr_en && sel.gen_b),
        .wdata   (bus_wdata),
        .gen_a_q (gen_a_q),
        .gen_b_q (gen_b_q),
        .led_out (led_out)
    );

    cfg_xact_unit #(.NUM_OSC(NUM_OSC), .OSC_RESET(OSC_RESET)) u_xact (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_cmd  (wr_en && sel.cmd),
        .wr_dout (wr_en && sel.dout),
        .wdata   (bus_wdata),
        .cmd_q   (cmd_q),
        .stat_q  (stat_q),
        .dout_q  (dout_q),
        .rtn_q   (rtn_q)
    );

    cfg_lock_reg u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (wr_en && sel.lock),
        .wdata       (bus_wdata),
        .loop_locked (loop_locked),
        .lock_word   (lock_word)
    );

    // Return the addressed word during a read, zero otherwise
    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_write) begin
            unique case (1'b1)
                sel.gen_a:  bus_rdata = gen_a_q;
                sel.gen_b:  bus_rdata = gen_b_q;
                sel.fixcfg: bus_rdata = FIXCFG_VAL;
                sel.rtn:    bus_rdata = rtn_q;
                sel.dout:   bus_rdata = dout_q;
                sel.cmd:    bus_rdata = cmd_q;
                sel.stat:   bus_rdata = stat_q;
                sel.lock:   bus_rdata = lock_word;
                sel.auxid:  bus_rdata = AUXID_VAL;
                sel.id:     bus_rdata = ID_VAL;
                default:    bus_rdata = '0;
            endcase
        end
    end

    // R2
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |-> (bus_rdata == '0));
endmodule

// File: tb/sys_cfg_ctrl_tb.sv
module sys_cfg_ctrl_tb;
    localparam int CLK_P = 10;
    localparam logic [31:0] FIXV = 32'h0000_0000;
    localparam logic [31:0] AUXV = 32'h0100_0001;
    localparam logic [31:0] IDV  = 32'h4104_0000;
    localparam logic [31:0] KEEP = 32'h43F0_0FFF;

    logic        clk = 0, rst_n = 0, bus_valid = 0, bus_write = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [7:0]  loop_locked = 8'hFF, led_out;

    int checks = 0, fails = 0;
    bit finished = 0;

    // Reference model state
    logic [31:0] m_a, m_b, m_dout, m_rtn, m_cmd, m_stat;
    logic [7:0]  m_mask;
    logic [31:0] m_osc [3];

    sys_cfg_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .loop_locked(loop_locked), .led_out(led_out)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        case ({a[11:2], 2'b00})
            12'h000: return m_a;
            12'h004: return m_b;
            12'h010: return FIXV;
            12'h0A0: return m_rtn;
            12'h0A4: return m_dout;
            12'h0A8: return m_cmd;
            12'h0AC: return m_stat;
            12'h100: return {m_mask, loop_locked, 15'd0, |(m_mask & loop_locked)};
            12'hFF8: return AUXV;
            12'hFFC: return IDV;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [11:0] a);
        case ({a[11:2], 2'b00})
            12'h000, 12'h004: return "R11";
            12'h0A0:          return "R8";
            12'h0A4:          return "R7";
            12'h0A8:          return "R4";
            12'h0AC:          return "R5/R6";
            12'h100:          return "R10";
            default:          return "R2";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_check(input logic [11:0] a, input string tag);
        logic [31:0] d;
        rd(a, d);
        check(tag, d, exp_read(a));
    endtask

    // Model one bus write
    task automatic model_wr(input logic [11:0] a, input logic [31:0] v);
        logic [11:0] dv;
        logic [5:0]  fn;
        bit ok;
        case ({a[11:2], 2'b00})
            12'h000: m_a = v;
            12'h004: m_b = v;
            12'h0A4: m_dout = v;
            12'h100: m_mask = v[31:24];
            12'h0A8: begin
                m_cmd  = v & KEEP;
                m_stat = 0;
                dv = v[11:0];
                fn = v[25:20];
                ok = (fn == 6'd1) && (dv < 12'd3);
                if (v[31]) begin
                    m_stat = {30'd0, !ok, 1'b1};
                    if (ok) begin
                        if (v[30]) m_osc[dv[1:0]] = m_dout;
                        else       m_rtn = m_osc[dv[1:0]];
                    end
                end
            end
            default: ;
        endcase
    endtask

    task automatic do_wr(input logic [11:0] a, input logic [31:0] v);
        wr(a, v);
        model_wr(a, v);
    endtask

    task automatic check_all(input string tag);
        logic [11:0] map [11] = '{12'h000, 12'h004, 12'h00C, 12'h010, 12'h0A0,
                                   12'h0A4, 12'h0A8, 12'h0AC, 12'h100, 12'hFF8, 12'hFFC};
        for (int k = 0; k < 11; k++)
            rd_check(map[k], (tag == "") ? tag_of(map[k]) : tag);
        #1 check((tag == "") ? "R11" : tag, {24'd0, led_out}, {24'd0, m_b[7:0]});
    endtask

    function automatic logic [31:0] rand_cmd();
        logic [11:0] dv;
        logic [5:0]  fn;
        dv = ($urandom_range(0, 9) == 0) ? 12'($urandom) : 12'($urandom_range(0, 4));
        fn = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'd1;
        return {($urandom_range(0, 4) != 0), 1'($urandom), 4'($urandom), fn, 8'($urandom), dv};
    endfunction

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));
        m_a = 0; m_b = 0; m_dout = 0; m_rtn = 0; m_cmd = 32'h0010_0000; m_stat = 0;
        m_mask = 8'hFF;
        m_osc[0] = 32'd50000000; m_osc[1] = 32'd24576000; m_osc[2] = 32'd25000000;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        check_all("R1");

        // R9 oscillator reset values through read transactions
        for (int i = 0; i < 3; i++) begin
            do_wr(12'h0A8, 32'h8010_0000 | i);
            rd_check(12'h0A0, "R9");
            rd_check(12'h0AC, "R9");
        end

        // R3 writes to read-only and unmapped offsets
        do_wr(12'h00C, 32'hFFFF_FFFF);
        do_wr(12'h010, 32'h1234_5678);
        do_wr(12'hFF8, 32'hDEAD_BEEF);
        do_wr(12'hFFC, 32'hCAFE_F00D);
        do_wr(12'h0A0, 32'h5555_AAAA);
        do_wr(12'h0AC, 32'h0000_0003);
        do_wr(12'h200, 32'hFFFF_FFFF);
        do_wr(12'h7F0, 32'hFFFF_FFFF);
        check_all("R3");
        rd_check(12'h7F0, "R3");

        // R10 empty mask gives a zero combined bit; low bits not writable
        do_wr(12'h100, 32'h00FF_FFFF);
        loop_locked = 8'hFF;
        rd_check(12'h100, "R10");
        do_wr(12'h100, 32'h0400_0000);
        loop_locked = 8'hFB;
        rd_check(12'h100, "R10");
        loop_locked = 8'h04;
        rd_check(12'h100, "R10");

        // R8 failed read keeps returned data; R7 write then read back
        do_wr(12'h0A4, 32'hA5A5_0001);
        do_wr(12'h0A8, 32'hC010_0002);
        do_wr(12'h0A8, 32'h8010_0002);
        rd_check(12'h0A0, "R7");
        do_wr(12'h0A8, 32'h8010_0003);
        rd_check(12'h0A0, "R8");
        rd_check(12'h0AC, "R6");
        do_wr(12'h0A8, 32'h8020_0000);
        rd_check(12'h0AC, "R6");
        // R5 command write without go clears status
        do_wr(12'h0A8, 32'h3FFF_FFFF);
        rd_check(12'h0AC, "R5");
        rd_check(12'h0A8, "R4");

        // Random mix
        for (int it = 0; it < 300; it++) begin
            int op;
            logic [11:0] a;
            logic [31:0] v;
            op = $urandom_range(0, 7);
            v  = $urandom;
            case (op)
                0: a = 12'h000;
                1: a = 12'h004;
                2: a = 12'h0A4;
                3, 4: begin a = 12'h0A8; v = rand_cmd(); end
                5: a = 12'h100;
                6: a = {$urandom_range(0, 1023), 2'b00};
                default: begin a = 12'h0A8; v = {1'b1, 1'b0, 4'd0, 6'd1, 8'd0, 12'($urandom_range(0, 3))}; end
            endcase
            loop_locked = 8'($urandom);
            do_wr(a, v);
            if (it % 4 == 0) check_all("");
            else begin
                rd_check(12'h0A0, tag_of(12'h0A0));
                rd_check(12'h0AC, tag_of(12'h0AC));
                rd_check(a, tag_of(a));
            end
        end

        @(negedge clk);
        bus_valid = 0;
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule